// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block is the device-side end of a byte-wide command channel. A host writes a command one byte at a time into a data port, checks a status byte to learn whether more bytes are wanted, and then sets a go bit to start execution. When the response is ready, the host reads it back through the same port, one byte per access. A 16-bit burst count tells the host how many bytes it may move without polling again. A zero count means the host should wait.

The engine takes the command's total length from the big-endian size field in the header. It keeps the data-expect flag raised until that many bytes have arrived, and never before the full ten-byte header is in. A built-in stub executor stands in for the real command processor. After a fixed latency it presents a fixed-length response made of the first bytes of the command, in their original order. The command bytes are not interpreted. Writing the command-ready bit aborts whatever is in progress.

Top module: `cfs_engine`

## Requirements
- R1: After reset the status byte reads 0xC8 (valid, command-ready and data-expect set) and the burst count reads DEPTH (64: low byte 0x40 at offset 0x19, high byte 0x00 at offset 0x1A).
- R2: The status byte at offset 0x18 carries valid in bit 7, command-ready in bit 6, go in bit 5 (always reads 0), data-available in bit 4 and data-expect in bit 3; bits 2..0 read 0.
- R3: The burst count is 16 bits, with the low byte at 0x19 and the high byte at 0x1A. While a command is being taken in it equals DEPTH minus the bytes written. During execution it reads 0. While a response is out it equals the response bytes not yet read.
- R4: Each write to the data port at offset 0x24 stores one byte in arrival order. The first such write leaves the command-ready state.
- R5: Command bytes 2..5 form the big-endian length. Data-expect stays 1 until at least 10 bytes and at least that length have been written, and then reads 0.
- R6: A data-port write is ignored while data-expect is 0, and it is also ignored during execution or while a response is out. The burst count and the response bytes stay unchanged.
- R7: A status write with bit 5 set starts execution only once a command is complete (data-expect 0, not command-ready). At any other time it has no effect on the status byte.
- R8: Exactly LAT cycles (8) after go is accepted, the status byte reads 0x90 (valid and data-available). The burst count then equals RESP_LEN (10), and the response is the first RESP_LEN command bytes in order.
- R9: Each data-port read in the response phase returns the next response byte and lowers the burst count by one. After the last byte, data-available reads 0 and the burst count reads 0. Further reads return 0x00.
- R10: A status write with bit 6 set returns the engine to command-ready from any state, discarding all bytes. This takes precedence over bit 5 in the same write.
- R11: The valid bit reads 0 in the cycle immediately after any data-port write and reads 1 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one byte per cycle |
| bus_rd | input | 1 | Register read strobe; a data-port read consumes a byte |
| bus_addr | input | ADDR_W | Byte offset within the locality window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |

## Verification
The assertions assume the host raises at most one of write or read per cycle. They also assume read and write strobes are single-cycle accesses decoded against a stable address. The bench keeps to this by performing exactly one access per clock, with idle cycles spent as side-effect-free status reads. The checks also assume commands never claim more than DEPTH bytes. All stimulus lengths fit in the buffer, so the wait-forever case of an oversize length is never entered.

// File: rtl/cfs_pkg.sv
// Package: shared encodings for the command/response FIFO status engine.
// Assumes byte-wide register accesses within one locality window.
package cfs_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_RECV  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_RESP  = 2'd3
    } cfs_state_e;

    localparam int HDR_BYTES  = 10;
    localparam int SIZE_FIRST = 2;
    localparam int SIZE_LAST  = 5;

    localparam int STS_VALID  = 7;
    localparam int STS_CMDRDY = 6;
    localparam int STS_GO     = 5;
    localparam int STS_AVAIL  = 4;
    localparam int STS_EXPECT = 3;

    localparam int OFS_STS      = 'h18;
    localparam int OFS_BURST_LO = 'h19;
    localparam int OFS_BURST_HI = 'h1A;
    localparam int OFS_FIFO     = 'h24;
endpackage

// File: rtl/cfs_byte_store.sv
// Module: byte storage shared by command and response.
// Does: one synchronous write port, one combinational read port.
// Assumes: indices below DEPTH; contents are not reset.
module cfs_byte_store #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    // Store an accepted command byte.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/cfs_stub_exec.sv
// Module: stand-in command executor.
// Does: raises done in the LAT-th consecutive cycle of run.
// Assumes: run stays high until done or an abort drops it.
module cfs_stub_exec #(
    parameter int LAT = 8,
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    logic [CNT_W-1:0] cnt;

    // Count cycles spent executing; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == CNT_W'(LAT - 1));

    assert_exec_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CNT_W'(LAT)));
endmodule

// File: rtl/cfs_ctrl.sv
// Module: phase control, counters and status/burst composition.
// Does: tracks command intake, length capture, go, response drain, abort.
// Assumes: at most one access per cycle; RESP_LEN <= DEPTH.
module cfs_ctrl
    import cfs_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int RESP_LEN = 10,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_wr,
    input  logic             fifo_rd,
    input  logic             sts_wr,
    input  logic [7:0]       wdata,
    input  logic             exec_done,
    output logic             exec_run,
    output logic             store_we,
    output logic [IDX_W-1:0] store_widx,
    output logic [IDX_W-1:0] store_ridx,
    output logic [7:0]       status_byte,
    output logic [15:0]      burst
);
    cfs_state_e       state;
    logic [CNT_W-1:0] wcount;
    logic [CNT_W-1:0] rptr;
    logic [31:0]      size_q;
    logic             wr_seen;

    logic need_more, expect_more, accept_wr, accept_rd, abort, go, avail;
    logic [CNT_W-1:0] resp_left;

    // Decode what the current access is allowed to do.
    always_comb begin
        need_more   = (wcount < CNT_W'(HDR_BYTES)) || (32'(wcount) < size_q);
        expect_more = (state == ST_READY) || ((state == ST_RECV) && need_more);
        accept_wr   = fifo_wr && expect_more && (wcount < CNT_W'(DEPTH));
        abort       = sts_wr && wdata[STS_CMDRDY];
        go          = sts_wr && wdata[STS_GO] && !abort
                      && (state == ST_RECV) && !expect_more;
        avail       = (state == ST_RESP) && (rptr < CNT_W'(RESP_LEN));
        accept_rd   = fifo_rd && avail;
        resp_left   = CNT_W'(RESP_LEN) - rptr;
    end

    // Phase sequencing: ready -> receive -> execute -> response.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= ST_READY;
        end else begin
            unique case (state)
                ST_READY: if (accept_wr) state <= ST_RECV;
                ST_RECV:  if (go)        state <= ST_EXEC;
                ST_EXEC:  if (exec_done) state <= ST_RESP;
                default:  ;
            endcase
        end
    end

    // Count accepted command bytes and shift in the big-endian size.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            wcount <= '0;
            size_q <= '0;
        end else if (accept_wr) begin
            wcount <= wcount + 1'b1;
            if (wcount >= CNT_W'(SIZE_FIRST) && wcount <= CNT_W'(SIZE_LAST)) begin
                size_q <= {size_q[23:0], wdata};
            end
        end
    end

    // Advance the response read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || abort || exec_done) begin
            rptr <= '0;
        end else if (accept_rd) begin
            rptr <= rptr + 1'b1;
        end
    end

    // Remember a data-port write for one cycle to drop the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen <= 1'b0;
        end else begin
            wr_seen <= fifo_wr;
        end
    end

    // Compose the status byte and the burst count.
    always_comb begin
        status_byte             = '0;
        status_byte[STS_VALID]  = !wr_seen;
        status_byte[STS_CMDRDY] = (state == ST_READY);
        status_byte[STS_AVAIL]  = avail;
        status_byte[STS_EXPECT] = expect_more;
        unique case (state)
            ST_READY, ST_RECV: burst = 16'(CNT_W'(DEPTH) - wcount);
            ST_EXEC:           burst = '0;
            default:           burst = 16'(resp_left);
        endcase
    end

    assign exec_run   = (state == ST_EXEC);
    assign store_we   = accept_wr;
    assign store_widx = wcount[IDX_W-1:0];
    assign store_ridx = rptr[IDX_W-1:0];

    assert_wcount_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wcount <= CNT_W'(DEPTH));
    assert_exec_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && $past(state) != ST_EXEC) |-> $past(sts_wr && wdata[STS_GO]));
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && wdata[STS_CMDRDY]) |=> (state == ST_READY && wcount == '0));
    assert_valid_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> !status_byte[STS_VALID]);
    assert_avail_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && status_byte[STS_AVAIL] && !sts_wr && burst == 16'd1)
        |=> !status_byte[STS_AVAIL]);
endmodule

// File: rtl/cfs_engine.sv
// Module: top of the command/response FIFO status engine.
// Does: decodes byte offsets, wires control, storage and stub executor.
// Assumes: bus_addr is the offset inside one locality window.
module cfs_engine
    import cfs_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int RESP_LEN = 10,
    parameter int LAT      = 8,
    parameter int ADDR_W   = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic             hit_sts, hit_fifo, hit_blo, hit_bhi;
    logic             exec_run, exec_done, store_we;
    logic [IDX_W-1:0] store_widx, store_ridx;
    logic [7:0]       store_rdata, status_byte;
    logic [15:0]      burst;

    // Offset decode.
    always_comb begin
        hit_sts  = (bus_addr == ADDR_W'(OFS_STS));
        hit_blo  = (bus_addr == ADDR_W'(OFS_BURST_LO));
        hit_bhi  = (bus_addr == ADDR_W'(OFS_BURST_HI));
        hit_fifo = (bus_addr == ADDR_W'(OFS_FIFO));
    end

    cfs_ctrl #(.DEPTH(DEPTH), .RESP_LEN(RESP_LEN)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_wr     (bus_wr && hit_fifo),
        .fifo_rd     (bus_rd && hit_fifo),
        .sts_wr      (bus_wr && hit_sts),
        .wdata       (bus_wdata),
        .exec_done   (exec_done),
        .exec_run    (exec_run),
        .store_we    (store_we),
        .store_widx  (store_widx),
        .store_ridx  (store_ridx),
        .status_byte (status_byte),
        .burst       (burst)
    );

    cfs_byte_store #(.DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .we    (store_we),
        .widx  (store_widx),
        .wdata (bus_wdata),
        .ridx  (store_ridx),
        .rdata (store_rdata)
    );

    cfs_stub_exec #(.LAT(LAT)) i_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (exec_run),
        .done  (exec_done)
    );

    // Read data multiplexer; data port returns 0 when nothing is available.
    always_comb begin
        bus_rdata = '0;
        if (hit_sts)       bus_rdata = status_byte;
        else if (hit_blo)  bus_rdata = burst[7:0];
        else if (hit_bhi)  bus_rdata = burst[15:8];
        else if (hit_fifo) bus_rdata = status_byte[STS_AVAIL] ? store_rdata : 8'h00;
    end
endmodule

// File: tb/test_cfs_engine.sv
module test_cfs_engine;
    localparam int DEPTH = 64;
    localparam int RL    = 10;
    localparam int LAT   = 8;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    always #2 clk = ~clk;

    cfs_engine i_cfs_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    logic [7:0] last_rd;

    // Behavioural reference: 0 ready, 1 receive, 2 execute, 3 response.
    int mst = 0, wc = 0, ln = 0, rp = 0, ec = 0;
    bit mv = 1;
    int mmem [DEPTH];

    function automatic bit m_exp();
        return (mst == 0) || (mst == 1 && (wc < 10 || wc < ln));
    endfunction

    function automatic logic [7:0] m_read(logic [7:0] a);
        int b;
        b = (mst <= 1) ? DEPTH - wc : (mst == 2) ? 0 : RL - rp;
        case (a)
            8'h18: return {mv, mst == 0, 1'b0, mst == 3 && rp < RL, m_exp(), 3'b000};
            8'h19: return 8'(b);
            8'h1A: return 8'(b >> 8);
            8'h24: return (mst == 3 && rp < RL) ? 8'(mmem[rp]) : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_step(bit w, bit r, logic [7:0] a, logic [7:0] d);
        int was;
        was = mst;
        mv = !(w && a == 8'h24);
        if (w && a == 8'h24 && (mst <= 1) && m_exp() && wc < DEPTH) begin
            mmem[wc] = d;
            if (wc >= 2 && wc <= 5) ln = (ln << 8) | d;
            wc++;
            mst = 1;
        end
        if (r && a == 8'h24 && mst == 3 && rp < RL) rp++;
        if (w && a == 8'h18 && d[6]) begin
            mst = 0; wc = 0; ln = 0; rp = 0;
        end else if (w && a == 8'h18 && d[5] && was == 1 && !m_exp()) begin
            mst = 2; ec = 0;
        end else if (was == 2) begin
            ec++;
            if (ec == LAT) begin mst = 3; rp = 0; end
        end
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // One access per clock; every read is compared with the reference.
    task automatic acc(bit w, bit r, logic [7:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        #1;
        if (r) begin
            last_rd = bus_rdata;
            check({tag, " (model)"}, bus_rdata, m_read(a));
        end
        @(posedge clk);
        m_step(w, r, a, d);
    endtask

    task automatic sts(string tag);   acc(0, 1, 8'h18, 8'h00, tag); endtask
    task automatic blo(string tag);   acc(0, 1, 8'h19, 8'h00, tag); endtask
    task automatic bhi(string tag);   acc(0, 1, 8'h1A, 8'h00, tag); endtask
    task automatic put(logic [7:0] b); acc(1, 0, 8'h24, b, "R4 fifo write"); endtask
    task automatic ctl(logic [7:0] b); acc(1, 0, 8'h18, b, "R10 status write"); endtask

    logic [7:0] cmd_a [12] = '{8'h00, 8'hC1, 8'h00, 8'h00, 8'h00, 8'h0C,
                               8'h00, 8'h00, 8'h00, 8'h99, 8'hAA, 8'hBB};
    logic [7:0] cmd_b [10] = '{8'h00, 8'hC1, 8'h00, 8'h00, 8'h00, 8'h04,
                               8'h01, 8'h02, 8'h03, 8'h04};

    initial begin
        #(200000 * 4);
        if (!finished) begin
            vectors++; miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset state
        sts("R1 status");   check("R1 status after reset", last_rd, 8'hC8);
        blo("R1 burst lo"); check("R1 burst lo after reset", last_rd, 8'h40);
        bhi("R1 burst hi"); check("R1 burst hi after reset", last_rd, 8'h00);

        // R4 / R11: partial command, valid drops one cycle
        put(8'h00); put(8'hC1); put(8'h00);
        sts("R11 status"); check("R11 valid low after fifo write", last_rd, 8'h08);
        sts("R2 status");  check("R2 receiving, expect set", last_rd, 8'h88);

        // R7: go while data still expected is ignored
        acc(1, 0, 8'h18, 8'h20, "R7 early go");
        sts("R7 status"); check("R7 early go ignored", last_rd, 8'h88);

        // R10: abort back to ready
        ctl(8'h40);
        sts("R10 status");   check("R10 abort to ready", last_rd, 8'hC8);
        blo("R10 burst lo"); check("R10 burst restored", last_rd, 8'h40);

        // R5 / R3: full 12-byte command
        for (int i = 0; i < 10; i++) put(cmd_a[i]);
        sts("R5 status");   check("R5 expect held past header", last_rd, 8'h08);
        blo("R3 burst lo"); check("R3 free space after 10", last_rd, 8'h36);
        put(cmd_a[10]); put(cmd_a[11]);
        sts("R5 status"); check("R5 expect cleared, valid low", last_rd, 8'h00);
        sts("R5 status"); check("R5 expect cleared", last_rd, 8'h80);

        // R6: surplus write ignored
        put(8'h55);
        blo("R6 burst lo"); check("R6 surplus write ignored", last_rd, 8'h34);

        // R8: go, execute, response ready
        acc(1, 0, 8'h18, 8'h20, "R7 go");
        sts("R7 status");   check("R7 executing", last_rd, 8'h80);
        blo("R3 burst lo"); check("R3 burst zero while executing", last_rd, 8'h00);
        for (int i = 0; i < LAT; i++) sts("R8 wait");
        sts("R8 status");   check("R8 response ready", last_rd, 8'h90);
        blo("R8 burst lo"); check("R8 burst equals response length", last_rd, 8'h0A);

        // R6: write during response ignored
        put(8'hEE);
        blo("R6 burst lo"); check("R6 write in response ignored", last_rd, 8'h0A);

        // R9: drain response
        for (int i = 0; i < RL; i++) begin
            acc(0, 1, 8'h24, 8'h00, "R9 fifo read");
            check("R9 response byte", last_rd, cmd_a[i]);
            if (i == 4) begin
                blo("R9 burst lo"); check("R9 burst after five reads", last_rd, 8'h05);
            end
        end
        sts("R9 status");   check("R9 avail cleared", last_rd, 8'h80);
        blo("R9 burst lo"); check("R9 burst zero when drained", last_rd, 8'h00);
        acc(0, 1, 8'h24, 8'h00, "R9 extra read");
        check("R9 empty read returns zero", last_rd, 8'h00);

        // R5: short length, header bound governs
        ctl(8'h40);
        for (int i = 0; i < 9; i++) put(cmd_b[i]);
        sts("R5 status"); check("R5 header incomplete", last_rd, 8'h08);
        put(cmd_b[9]);
        sts("R5 status"); sts("R5 status");
        check("R5 short length done at header", last_rd, 8'h80);

        // R10: abort has priority over go
        ctl(8'h60);
        sts("R10 status"); check("R10 abort beats go", last_rd, 8'hC8);

        // R10: abort during execution
        for (int i = 0; i < 12; i++) put(cmd_a[i]);
        acc(1, 0, 8'h18, 8'h20, "R7 go");
        sts("R10 wait"); sts("R10 wait");
        ctl(8'h40);
        sts("R10 status");   check("R10 abort during execution", last_rd, 8'hC8);
        for (int i = 0; i < LAT + 2; i++) sts("R10 stays ready");
        check("R10 no stale response", last_rd, 8'hC8);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule